// File: doc/BRIEF.md
# Sticky Interrupt Aggregator with Configurable Request Pin

This block collects six event pulses from the clock-synchronisation logic into sticky status bits. Each bit has its own enable. The enabled, pending bits are ORed into one interrupt request. Software reads the status, clears bits by writing ones, and masks sources through an enable register.

A configuration register sets the active level of the request pin. It also chooses whether the pin drives its inactive level or floats while no enabled source is pending. The pin is brought out as a level and an output-enable, so the pad ring can build the tri-state buffer.

A separate routing bit can mirror the failure status of the selected primary input clock onto a second flag output.

Top module: `irq_sticky_agg`

## Requirements
- R1: Each event input sets its own status bit, and the new value is visible after the next rising clock edge. Bit order: 0 = secondary loop lock change, 1 = primary input validity change, 2 = primary selected input fail, 3 = secondary path without qualified input, 4 = primary loop mode switch, 5 = external sync alarm.
- R2: A set status bit stays set until software clears it.
- R3: Writing to address 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: The enable register sits at address 1. The request is active exactly when some status bit and its enable bit are both 1.
- R6: Clearing an enable bit removes that source from the request but keeps its status bit. Setting the enable bit again reasserts the request.
- R7: Configuration is at address 2. Bit 0 set means the request is active-high (`irqLevel` = 1 when active). Bit 0 clear means active-low.
- R8: Configuration bit 1 set makes `irqOutEn` 0 while the request is inactive. With bit 1 clear, `irqOutEn` is always 1. While the request is active, `irqOutEn` is 1. When inactive, `irqLevel` shows the inactive level.
- R9: With configuration bit 2 set, `flagOut` equals status bit 2. With bit 2 clear, `flagOut` is 0.
- R10: `regRdData` returns status, enable and configuration at addresses 0, 1 and 2, zero-extended. Address 3 reads 0, and writes to address 3 change nothing.
- R11: Reset clears status, enable and configuration. After reset the pin is therefore inactive, active-low and driven: `irqLevel` = 1 and `irqOutEn` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtIn | input | 6 | Single-cycle event pulses, one per source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| irqLevel | output | 1 | Request pin level |
| irqOutEn | output | 1 | Request pin output enable (0 = high impedance) |
| flagOut | output | 1 | Mirrored primary input fail flag |

## Verification
Every result appears one rising edge after its stimulus. This covers status, enable and configuration writes, and the pin level, output-enable and flag that follow from them combinationally. Read data follows the address with no delay.

The bench drives each step at a falling edge and waits for one rising edge. It then returns the inputs to idle with address 0 and samples a few nanoseconds later. The status readback and the pin values checked there are therefore the ones set by that single edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Write strobes passed from control to datapath
  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrConfig;
  } regStrobeT;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_CONFIG = 2;

  localparam int CFG_POL_BIT   = 0;
  localparam int CFG_HZ_BIT    = 1;
  localparam int CFG_ROUTE_BIT = 2;
  localparam int CFG_W         = 3;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobeT         strobe
);
  always_comb begin
    strobe.wrStatus = regWrEn && (regAddr == ADDR_W'(ADDR_STATUS));
    strobe.wrEnable = regWrEn && (regAddr == ADDR_W'(ADDR_ENABLE));
    strobe.wrConfig = regWrEn && (regAddr == ADDR_W'(ADDR_CONFIG));
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int FAIL_IDX = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  regStrobeT          strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqLevel,
  output logic               irqOutEn,
  output logic               flagOut
);
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [CFG_W-1:0]   cfgQ;
  logic               pending;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                statusQ[i] <= 1'b0;
      else if (evtIn[i])                        statusQ[i] <= 1'b1;
      else if (strobe.wrStatus && wrData[i])    statusQ[i] <= 1'b0;
    end

    // R1
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[i] |=> statusQ[i]);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !(strobe.wrStatus && wrData[i])) |=> statusQ[i]);

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrStatus && wrData[i] && !evtIn[i]) |=> !statusQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      cfgQ    <= '0;
    end else begin
      if (strobe.wrEnable) enableQ <= wrData[NUM_SRC-1:0];
      if (strobe.wrConfig) cfgQ    <= wrData[CFG_W-1:0];
    end
  end

  assign pending  = |(statusQ & enableQ);
  assign irqLevel = cfgQ[CFG_POL_BIT] ? pending : ~pending;
  assign irqOutEn = pending | ~cfgQ[CFG_HZ_BIT];
  assign flagOut  = cfgQ[CFG_ROUTE_BIT] & statusQ[FAIL_IDX];

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(ADDR_STATUS): rdData[NUM_SRC-1:0] = statusQ;
      ADDR_W'(ADDR_ENABLE): rdData[NUM_SRC-1:0] = enableQ;
      ADDR_W'(ADDR_CONFIG): rdData[CFG_W-1:0]   = cfgQ;
      default:              rdData = '0;
    endcase
  end

  // R5
  req_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !$past(pending)) |-> $past((|evtIn) || strobe.wrEnable));

  // R6
  mask_keeps_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnable |=> statusQ == ($past(statusQ) | $past(evtIn)));
endmodule

// File: rtl/irq_sticky_agg.sv
module irq_sticky_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int FAIL_IDX = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqLevel,
  output logic               irqOutEn,
  output logic               flagOut
);
  regStrobeT strobe;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  irq_agg_dp #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .FAIL_IDX(FAIL_IDX)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .strobe  (strobe),
    .wrData  (regWrData),
    .rdAddr  (regAddr),
    .rdData  (regRdData),
    .irqLevel(irqLevel),
    .irqOutEn(irqOutEn),
    .flagOut (flagOut)
  );
endmodule

// File: tb/irq_sticky_agg_test.sv
`timescale 1ns/1ps
module irq_sticky_agg_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] evtIn = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqLevel, irqOutEn, flagOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  irq_sticky_agg uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqLevel(irqLevel), .irqOutEn(irqOutEn), .flagOut(flagOut)
  );

  typedef struct packed {
    logic [5:0] evt;
    logic       we;
    logic [1:0] addr;
    logic [7:0] wd;
    logic       lvl;
    logic       oe;
    logic       flg;
    logic [5:0] st;
  } vecT;

  localparam int NV = 18;
  localparam vecT VECS [NV] = '{
    '{6'h00, 1'b1, 2'd1, 8'h3F, 1'b1, 1'b1, 1'b0, 6'h00}, // R5 enable all
    '{6'h01, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 6'h01}, // R1 event 0
    '{6'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 6'h01}, // R2 sticky
    '{6'h00, 1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 6'h01}, // R3 write 0
    '{6'h00, 1'b1, 2'd0, 8'h01, 1'b1, 1'b1, 1'b0, 6'h00}, // R3 write 1
    '{6'h00, 1'b1, 2'd2, 8'h01, 1'b0, 1'b1, 1'b0, 6'h00}, // R7 active high
    '{6'h04, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 6'h04}, // R9 route off
    '{6'h00, 1'b1, 2'd2, 8'h05, 1'b1, 1'b1, 1'b1, 6'h04}, // R9 route on
    '{6'h20, 1'b1, 2'd0, 8'h24, 1'b1, 1'b1, 1'b0, 6'h20}, // R4 event wins
    '{6'h00, 1'b1, 2'd1, 8'h00, 1'b0, 1'b1, 1'b0, 6'h20}, // R6 mask
    '{6'h00, 1'b1, 2'd2, 8'h03, 1'b0, 1'b0, 1'b0, 6'h20}, // R8 hz idle
    '{6'h00, 1'b1, 2'd1, 8'h20, 1'b1, 1'b1, 1'b0, 6'h20}, // R6 re-enable
    '{6'h00, 1'b1, 2'd0, 8'h20, 1'b0, 1'b0, 1'b0, 6'h00}, // R3 clear last
    '{6'h3F, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 6'h3F}, // R1 all events
    '{6'h00, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 6'h3F}, // R5 none enabled
    '{6'h00, 1'b1, 2'd3, 8'hFF, 1'b0, 1'b0, 1'b0, 6'h3F}, // R10 addr 3 write
    '{6'h00, 1'b1, 2'd2, 8'h06, 1'b1, 1'b0, 1'b1, 6'h3F}, // R8 low pol hz
    '{6'h00, 1'b1, 2'd0, 8'h3F, 1'b1, 1'b0, 1'b0, 6'h00}  // R3 clear all
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idleIn();
    evtIn = '0; regWrEn = 1'b0; regAddr = 2'd0; regWrData = '0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #2;
    idleIn();
    #2;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idleIn();
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    check("R11 level", {7'b0, irqLevel}, 8'h01);
    check("R11 outEn", {7'b0, irqOutEn}, 8'h01);
    check("R11 flag", {7'b0, flagOut}, 8'h00);
    check("R11 status", regRdData, 8'h00);
    @(negedge clk); rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      evtIn = VECS[k].evt; regWrEn = VECS[k].we;
      regAddr = VECS[k].addr; regWrData = VECS[k].wd;
      @(posedge clk); #2;
      idleIn();
      #2;
      check($sformatf("R1-step%0d level", k), {7'b0, irqLevel}, {7'b0, VECS[k].lvl});
      check($sformatf("R8 step%0d outEn", k), {7'b0, irqOutEn}, {7'b0, VECS[k].oe});
      check($sformatf("R9 step%0d flag", k), {7'b0, flagOut}, {7'b0, VECS[k].flg});
      check($sformatf("R2 step%0d status", k), regRdData, {2'b0, VECS[k].st});
    end

    // R10 readback of enable and configuration, and addr 3
    regWrite(2'd1, 8'hFF);
    regAddr = 2'd1; #1;
    check("R10 enable read", regRdData, 8'h3F);
    regWrite(2'd2, 8'hFD);
    regAddr = 2'd2; #1;
    check("R10 config read", regRdData, 8'h05);
    regAddr = 2'd3; #1;
    check("R10 addr3 read", regRdData, 8'h00);

    // R4 event wins with full clear on bit 2, flag follows (R9)
    @(negedge clk);
    evtIn = 6'h04; regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'hFF;
    @(posedge clk); #2; idleIn(); #2;
    check("R4 status", regRdData, 8'h04);
    check("R9 flag live", {7'b0, flagOut}, 8'h01);
    check("R7 active high", {7'b0, irqLevel}, 8'h01);

    // R11 reset mid-run
    @(negedge clk); rstN = 1'b0; #2;
    check("R11 status after reset", regRdData, 8'h00);
    check("R11 level after reset", {7'b0, irqLevel}, 8'h01);
    check("R11 outEn after reset", {7'b0, irqOutEn}, 8'h01);
    regAddr = 2'd2; #1;
    check("R11 config after reset", regRdData, 8'h00);
    @(negedge clk); rstN = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule